// File: doc/BRIEF.md
# Radix-2 Montgomery Multiplier with Zero-Step Merging

This block computes a Montgomery product of two operands for an odd modulus: the result is congruent to A·B·2^-ITER modulo N, where ITER is a parameter. It is one step of a larger modular-exponentiation flow, which sits outside the block. Operands are presented in parallel with a one-cycle `start` pulse. A `done` pulse marks a fresh result, and the result then stays on `result` until the next `done`.

Internally the running value is held as a sum vector and a carry vector. One full-adder row serves three purposes. First, it ripples B + N into binary before the loop. Second, it runs the loop, where every step adds exactly one operand picked from {0, N, B, B+N}. Third, it converts the final sum/carry pair back to binary. The quotient bit and the multiplier bit for the next step are registered one cycle ahead. When the step after the current one would add zero and the low bits allow an exact halving, both halvings happen in one clock. The loop runs ITER = K+2 steps, so no final subtraction is needed: an input B below 2N gives a result below 2N, which can be fed straight back in.

Top module: `mont_mul_skip`

## Requirements
- R1: For odd `n_in` below 2^K, `a_in` below 2^K and `b_in` below 2·`n_in`, the `result` reported with `done` is congruent to A·B·2^-ITER modulo N and is below 2·N.
- R2: `done` is high for exactly one cycle per accepted operation, and `result` keeps its value until the next `done`.
- R3: After reset, `busy` and `done` are 0 and `result` is 0.
- R4: A `start` seen while idle is accepted, and `busy` is 1 from the next cycle until `done`. A `start` while `busy` is 1 is ignored, and the running operation completes with its original operands.
- R5: Each loop step adds one operand chosen by the pair (A bit, quotient bit): 00 picks 0, 01 picks N, 10 picks B, 11 picks the precomputed B+N. The chosen quotient always makes the three-way sum even.
- R6: A step that would add zero is merged with the step before it. With `a_in` = 0 and `b_in` = 0, `done` comes no later than ITER/2 + 4 cycles after the `start` cycle.
- R7: The final conversion ends only when the carry vector is all zero. With all-ones A, N = 2^K−1 and B = 2N−1, the long carry chains still yield a correct R1 result.
- R8: With `a_in` = 0, the result is 0 for any B and N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; operands sampled with it |
| a_in | input | K | Multiplier operand A |
| b_in | input | K+1 | Multiplicand operand B, below 2N |
| n_in | input | K | Odd modulus N |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: `result` is new |
| result | output | K+1 | Binary Montgomery product |

## Verification
Two situations are hard to reach from the ports. The first is the merged double-halving path. It only fires when the next multiplier bit is zero and both low vector bits are clear, so random operands hit it unevenly. The all-zero operands force it on every step, and the cycle count from `start` to `done` shows that it was taken. The second is a carry ripple that spans the whole word. All-ones operands with N = 2^K−1 drive it in both the B+N precomputation and the final conversion. Random and directed operands are then checked against a model that reduces the full product and halves it modulo N.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_LOOP = 2'd2,
    ST_CONV = 2'd3
  } mm_state_t;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic par3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction
endpackage

// File: rtl/mm_csa.sv
module mm_csa #(
  parameter int W = 18
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W:0]   sum_o,
  output logic [W:0]   cry_o
);
  import mm_pkg::*;
  logic [W-1:0] maj_w;
  logic [W-1:0] par_w;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign par_w[g] = par3(x[g], y[g], z[g]);
    assign maj_w[g] = maj3(x[g], y[g], z[g]);
  end

  assign sum_o = {1'b0, par_w};
  assign cry_o = {maj_w, 1'b0};
endmodule

// File: rtl/mm_opsel.sv
module mm_opsel #(
  parameter int W = 18
) (
  input  logic         a_bit,
  input  logic         q_bit,
  input  logic [W-1:0] b_val,
  input  logic [W-1:0] n_val,
  input  logic [W-1:0] d_val,
  output logic [W-1:0] x_o
);
  always_comb begin
    unique case ({a_bit, q_bit})
      2'b00:   x_o = '0;
      2'b01:   x_o = n_val;
      2'b10:   x_o = b_val;
      default: x_o = d_val;
    endcase
  end
endmodule

// File: rtl/mm_lookahead.sv
module mm_lookahead (
  input  logic [2:0] s_lo,
  input  logic [2:0] c_lo,
  input  logic       a_n1,
  input  logic       a_n2,
  input  logic       b_lsb,
  input  logic       room,
  output logic       skip_o,
  output logic       q_next_o,
  output logic       a_next_o
);
  logic q_one;
  logic q_two;

  assign q_one    = s_lo[1] ^ c_lo[1] ^ (a_n1 & b_lsb);
  assign q_two    = s_lo[2] ^ c_lo[2] ^ (a_n2 & b_lsb);
  assign skip_o   = room & ~a_n1 & ~s_lo[1] & ~c_lo[1];
  assign q_next_o = skip_o ? q_two : q_one;
  assign a_next_o = skip_o ? a_n2 : a_n1;
endmodule

// File: rtl/mont_mul_skip.sv
module mont_mul_skip #(
  parameter int K    = 16,
  parameter int ITER = K + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] a_in,
  input  logic [K:0]   b_in,
  input  logic [K-1:0] n_in,
  output logic         busy,
  output logic         done,
  output logic [K:0]   result
);
  import mm_pkg::*;
  localparam int W  = K + 2;
  localparam int IW = $clog2(ITER + 3) + 1;

  mm_state_t    st_q;
  logic [K-1:0] a_op;
  logic [W-1:0] b_op, n_op, d_q, s_q, c_q;
  logic         abit_q, qbit_q;
  logic [IW-1:0] idx_q;

  logic [W-1:0] x_w;
  logic [W:0]   s1_w, c1_w;
  logic         skip_w, q_next_w, a_next_w;
  logic         c_zero_w, room_w, loop_end_w;
  logic [IW-1:0] idx_next_w;

  function automatic logic abit_at(input logic [K-1:0] a, input logic [IW-1:0] j);
    return (int'(j) < K) ? a[j[$clog2(K+1)-1:0]] : 1'b0;
  endfunction

  mm_opsel #(.W(W)) i_opsel (
    .a_bit(abit_q), .q_bit(qbit_q), .b_val(b_op), .n_val(n_op),
    .d_val(d_q), .x_o(x_w)
  );

  mm_csa #(.W(W)) i_csa (
    .x(s_q), .y(c_q), .z(x_w), .sum_o(s1_w), .cry_o(c1_w)
  );

  assign room_w = (int'(idx_q) + 1) < ITER;

  mm_lookahead i_look (
    .s_lo(s1_w[2:0]), .c_lo(c1_w[2:0]),
    .a_n1(abit_at(a_op, idx_q + IW'(1))),
    .a_n2(abit_at(a_op, idx_q + IW'(2))),
    .b_lsb(b_op[0]), .room(room_w),
    .skip_o(skip_w), .q_next_o(q_next_w), .a_next_o(a_next_w)
  );

  assign c_zero_w   = (c_q == '0);
  assign idx_next_w = skip_w ? idx_q + IW'(2) : idx_q + IW'(1);
  assign loop_end_w = int'(idx_next_w) >= ITER;
  assign busy       = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      a_op   <= '0;
      b_op   <= '0;
      n_op   <= '0;
      d_q    <= '0;
      s_q    <= '0;
      c_q    <= '0;
      abit_q <= 1'b0;
      qbit_q <= 1'b0;
      idx_q  <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          a_op   <= a_in;
          b_op   <= W'(b_in);
          n_op   <= W'(n_in);
          s_q    <= W'(b_in);
          c_q    <= W'(n_in);
          abit_q <= 1'b0;
          qbit_q <= 1'b0;
          st_q   <= ST_PRE;
        end
        ST_PRE: begin
          if (c_zero_w) begin
            d_q    <= s_q;
            s_q    <= '0;
            c_q    <= '0;
            abit_q <= a_op[0];
            qbit_q <= a_op[0] & b_op[0];
            idx_q  <= '0;
            st_q   <= ST_LOOP;
          end else begin
            s_q <= s1_w[W-1:0];
            c_q <= c1_w[W-1:0];
          end
        end
        ST_LOOP: begin
          if (skip_w) begin
            s_q <= W'(s1_w[W:2]);
            c_q <= W'(c1_w[W:2]);
          end else begin
            s_q <= s1_w[W:1];
            c_q <= c1_w[W:1];
          end
          idx_q <= idx_next_w;
          if (loop_end_w) begin
            abit_q <= 1'b0;
            qbit_q <= 1'b0;
            st_q   <= ST_CONV;
          end else begin
            abit_q <= a_next_w;
            qbit_q <= q_next_w;
          end
        end
        default: begin
          if (c_zero_w) begin
            result <= s_q[K:0];
            done   <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            s_q <= s1_w[W-1:0];
            c_q <= c1_w[W-1:0];
          end
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R2
  AST_EVEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOP) |-> ((s_q[0] ^ c_q[0] ^ x_w[0]) == 1'b0)); // R5
  AST_BUSY_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(a_op) && $stable(b_op) && $stable(n_op)); // R4
  AST_PRESUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOP && $past(st_q) == ST_LOOP) |-> $stable(d_q)); // R5
  AST_CONV_ZERO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st_q) == ST_CONV) && $past(c_zero_w)); // R7
  AST_ZERO_ADD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOP && skip_w) |-> !abit_at(a_op, idx_q + IW'(1))); // R6
endmodule

// File: tb/test_mont_mul_skip.sv
module test_mont_mul_skip;
  localparam int K    = 16;
  localparam int ITER = K + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [K-1:0] a_in = '0;
  logic [K:0]   b_in = '0;
  logic [K-1:0] n_in = '0;
  logic         busy, done;
  logic [K:0]   result;

  int n_checks = 0;
  int n_fail   = 0;
  bit timed_out = 1'b0;

  always #2.5 clk = ~clk;

  mont_mul_skip #(.K(K), .ITER(ITER)) i_mont_mul_skip (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .n_in(n_in), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model(input longint a, input longint b, input longint n);
    longint r = (a * b) % n;
    for (int i = 0; i < ITER; i++) begin
      if (r[0]) r = r + n;
      r = r >> 1;
    end
    return r;
  endfunction

  task automatic run_op(input longint a, input longint b, input longint n,
                        output longint res, output int cyc);
    @(negedge clk);
    a_in = K'(a); b_in = (K+1)'(b); n_in = K'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      timed_out = 1'b1;
      check("watchdog", 0, 1);
    end
    res = longint'(result);
  endtask

  task automatic check_mul(input string req, input longint a, input longint b, input longint n);
    longint res;
    int cyc;
    run_op(a, b, n, res, cyc);
    check(req, res % n, model(a, b, n));
    check(req, (res < 2 * n) ? 1 : 0, 1);
  endtask

  task automatic t_reset;
    check("R3 busy", busy, 0);
    check("R3 done", done, 0);
    check("R3 result", result, 0);
  endtask

  task automatic t_random;
    for (int t = 0; t < 40; t++) begin
      longint n = longint'($urandom_range(65535, 1)) | 1;
      longint a = longint'($urandom_range(65535, 0));
      longint b = longint'($urandom) % (2 * n);
      check_mul("R1 random", a, b, n);
    end
  endtask

  task automatic t_select_patterns;
    // R5: steps select only N, only B, or a B+N mix
    check_mul("R5 a_ones_b_even", 16'hFFFF, 17'd2, 16'd40961);
    check_mul("R5 b_odd", 16'h5555, 17'd12345, 16'd54321);
    check_mul("R5 small_n", 16'h00FF, 17'd3, 16'd3);
  endtask

  task automatic t_skip;
    longint res;
    int cyc;
    run_op(0, 0, 16'd65521, res, cyc);
    check("R6 result", res, 0);
    check("R6 cycles", (cyc <= ITER / 2 + 4) ? 1 : 0, 1);
  endtask

  task automatic t_zero_a;
    longint res;
    int cyc;
    run_op(0, 17'd60001, 16'd32771, res, cyc);
    check("R8 a_zero", res, 0);
  endtask

  task automatic t_long_carry;
    check_mul("R7 all_ones", 16'hFFFF, 2 * 65535 - 1, 16'hFFFF);
  endtask

  task automatic t_busy_ignore;
    longint res;
    int cyc;
    @(negedge clk);
    a_in = 16'd1234; b_in = 17'd999; n_in = 16'd4099; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 busy", busy, 1);
    @(negedge clk);
    a_in = 16'd7; b_in = 17'd5; n_in = 16'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 3;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    res = longint'(result);
    check("R4 ignored start", res % 4099, model(1234, 999, 4099));
    @(negedge clk);
    check("R2 done pulse", done, 0);
    check("R2 result held", result, res);
    check("R4 idle after", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select_patterns();
    t_skip();
    t_zero_a();
    t_long_carry();
    t_busy_ignore();
    t_random();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule